// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit down-counting channel of an interval timer. A write presents an initial count on `load_val` together with `load_stb`; the channel keeps that value in a holding register and raises the null-count flag. On the next clock edge it copies the value into its counting element, and the flag drops. Counting starts on the edge after that. Bus byte sequencing and control-word decoding sit outside the block. The operating mode and the number base arrive already decoded, on `mode_sel` and `bcd_sel`, and the channel samples them on the same edge as the count.

There are two operating modes. In the periodic divider mode the channel divides the clock by N and reloads itself. In the one-shot mode each count write starts a single countdown, and that countdown ends in a low strobe one clock wide. The counter runs in plain binary or in four-digit decimal. A count of zero means the largest count the chosen base can hold.

The controller has four named states. `ST_IDLE` is the reset state, with no count loaded. `ST_ARM` transfers the count. `ST_RUN` is counting. `ST_DONE` is the state after the one-shot strobe. The transitions are:
- load: any state goes to `ST_ARM` on `load_stb`.
- transfer: `ST_ARM` goes to `ST_RUN`.
- expire: `ST_RUN` goes to `ST_DONE` when a one-shot count steps from 1 to 0.
- hold: every other state stays where it is.

Top module: `pic_chan`

## Requirements
- R1: After reset `out_o` is 1 and `null_cnt_o` is 0.
- R2: Take a strobe sampled on clock edge E0. `null_cnt_o` reads 1 after E0 and reads 0 after E1, the transfer edge, unless another strobe arrives at E1.
- R3: One-shot mode (`mode_sel`=1). `out_o` is 0 for exactly one cycle, following edge E(N+1) counted from the write edge E0, and is 1 at every other time.
- R4: One-shot mode. After its strobe the channel gives no further pulse until a new count is written. A write made while a countdown is still running restarts the timing from that write, and the old countdown never produces a pulse.
- R5: Divider mode (`mode_sel`=0). `out_o` is 0 for one cycle after edges E(N), E(2N), E(3N) and so on, and is 1 at every other time.
- R6: Divider mode with a count of 1. `out_o` stays 1 at all times.
- R7: A count of 0 lasts 65536 clocks in binary (`bcd_sel`=0) and 10000 clocks in decimal.
- R8: Decimal mode (`bcd_sel`=1). Each 4-bit digit of the count, with the least significant digit in bits 3:0, wraps from 0 to 9 and borrows from the digit above it. A value of 16'h0100 therefore lasts 100 clocks.
- R9: While `gate` is 0 the count does not change, and `out_o` is 1. Each clock edge spent with `gate` at 0 delays the pulse by one cycle.
- R10: `out_o` reads 1 in the cycle after any count write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gate | input | 1 | Count enable; 0 holds the count |
| mode_sel | input | 1 | 0 selects the periodic divider, 1 selects the one-shot strobe |
| bcd_sel | input | 1 | 1 selects decimal counting, 0 selects binary |
| load_stb | input | 1 | Count write strobe, one cycle |
| load_val | input | 16 | Initial count |
| out_o | output | 1 | Timer output; the active pulse is low |
| null_cnt_o | output | 1 | A written count has not yet been transferred |

## Verification
The bench checks `out_o` on every cycle of each countdown, so any off-by-one between the write and the strobe shows up. That includes counting the transfer edge twice, and starting the decrement on the transfer edge itself.

Several cases target specific faults:
- Divider counts of 1 and 2 catch a reload comparator that is off by one. Such a design would either pulse every cycle or give a low level two cycles long.
- Zero counts in both bases, and a decimal count of 0100, catch a decrementer that borrows in binary. In decimal mode that design would finish after 256 or 65536 clocks.
- A write made partway through a one-shot countdown catches a design that lets the first countdown still fire.
- A gate pause catches a design that keeps counting while `gate` is low.

// File: rtl/pic_pkg.sv
package pic_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2,
        ST_DONE = 2'd3
    } chan_state_e;

    typedef enum logic {
        MODE_RATE   = 1'b0,
        MODE_STROBE = 1'b1
    } chan_mode_e;
endpackage

// File: rtl/pic_hold.sv
module pic_hold #(
    parameter int W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_stb,
    input  logic [W-1:0]         load_val,
    input  logic                 mode_in,
    input  logic                 bcd_in,
    input  logic                 xfer_i,
    output logic [W-1:0]         pend_val,
    output pic_pkg::chan_mode_e  pend_mode,
    output logic                 pend_bcd,
    output logic                 null_o
);
    import pic_pkg::*;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_val  <= '0;
            pend_mode <= MODE_RATE;
            pend_bcd  <= 1'b0;
            null_o    <= 1'b0;
        end else if (load_stb) begin
            pend_val  <= load_val;
            pend_mode <= chan_mode_e'(mode_in);
            pend_bcd  <= bcd_in;
            null_o    <= 1'b1;
        end else if (xfer_i) begin
            null_o    <= 1'b0;
        end
    end
endmodule

// File: rtl/pic_dec.sv
module pic_dec #(
    parameter int W = 16
) (
    input  logic [W-1:0] val_i,
    input  logic         bcd_i,
    output logic [W-1:0] val_o
);
    localparam int ND = W / 4;

    logic [ND-1:0] brw;
    logic [W-1:0]  bcd_v;

    assign brw[0] = 1'b1;

    for (genvar g = 0; g < ND; g++) begin : g_digit
        logic [3:0] dig;
        assign dig = val_i[4*g +: 4];
        assign bcd_v[4*g +: 4] = !brw[g]      ? dig :
                                 (dig == 4'd0) ? 4'd9 : dig - 4'd1;
        if (g < ND - 1) begin : g_chain
            assign brw[g+1] = brw[g] && (dig == 4'd0);
        end
    end

    assign val_o = bcd_i ? bcd_v : val_i - W'(1);
endmodule

// File: rtl/pic_chan.sv
module pic_chan #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         gate,
    input  logic         mode_sel,
    input  logic         bcd_sel,
    input  logic         load_stb,
    input  logic [15:0]  load_val,
    output logic         out_o,
    output logic         null_cnt_o
);
    import pic_pkg::*;

    localparam logic [W-1:0] ONE = W'(1);
    localparam logic [W-1:0] TWO = W'(2);

    chan_state_e state_q, state_d;
    chan_mode_e  mode_q, pend_mode;
    logic [W-1:0] cnt_q, cnt_dec, pend_val;
    logic         bcd_q, pend_bcd, out_q;

    pic_hold #(.W(W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_stb  (load_stb),
        .load_val  (W'(load_val)),
        .mode_in   (mode_sel),
        .bcd_in    (bcd_sel),
        .xfer_i    (state_q == ST_ARM),
        .pend_val  (pend_val),
        .pend_mode (pend_mode),
        .pend_bcd  (pend_bcd),
        .null_o    (null_cnt_o)
    );

    pic_dec #(.W(W)) u_dec (
        .val_i (cnt_q),
        .bcd_i (bcd_q),
        .val_o (cnt_dec)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (load_stb) begin
            state_d = ST_ARM;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_ARM:  state_d = ST_RUN;
                ST_RUN:  if (gate && mode_q == MODE_STROBE && cnt_q == ONE)
                             state_d = ST_DONE;
                ST_DONE: state_d = ST_DONE;
            endcase
        end
    end

    // counting element and output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            mode_q <= MODE_RATE;
            bcd_q  <= 1'b0;
            out_q  <= 1'b1;
        end else if (load_stb) begin
            out_q  <= 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: out_q <= 1'b1;
                ST_ARM: begin
                    cnt_q  <= pend_val;
                    mode_q <= pend_mode;
                    bcd_q  <= pend_bcd;
                    out_q  <= 1'b1;
                end
                ST_RUN: begin
                    if (!gate) begin
                        out_q <= 1'b1;
                    end else if (mode_q == MODE_STROBE) begin
                        cnt_q <= cnt_dec;
                        out_q <= (cnt_q != ONE);
                    end else if (cnt_q == ONE) begin
                        cnt_q <= pend_val;
                        out_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_dec;
                        out_q <= (cnt_q != TWO);
                    end
                end
                ST_DONE: out_q <= 1'b1;
            endcase
        end
    end

    assign out_o = out_q;
endmodule

// File: rtl/pic_chan_chk.sv
module pic_chan_chk (
    input logic clk,
    input logic rst_n,
    input logic load_stb,
    input logic out_o,
    input logic null_cnt_o
);
    AST_NULL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> null_cnt_o);                                  // R2
    AST_NULL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (null_cnt_o && !load_stb) |=> !null_cnt_o);                // R2
    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_o |=> out_o);                                         // R3
    AST_WRITE_OUT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> out_o);                                       // R10
    AST_NO_PULSE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        null_cnt_o |-> out_o);                                     // R10
endmodule

bind pic_chan pic_chan_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_stb   (load_stb),
    .out_o      (out_o),
    .null_cnt_o (null_cnt_o)
);

// File: tb/pic_chan_tb.sv
module pic_chan_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gate = 1'b1;
    logic mode_sel = 1'b0;
    logic bcd_sel = 1'b0;
    logic load_stb = 1'b0;
    logic [15:0] load_val = '0;
    logic out_o, null_cnt_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pic_chan u_dut (
        .clk(clk), .rst_n(rst_n), .gate(gate), .mode_sel(mode_sel),
        .bcd_sel(bcd_sel), .load_stb(load_stb), .load_val(load_val),
        .out_o(out_o), .null_cnt_o(null_cnt_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 200000 && !done) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run did not finish, act=hung exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: act=%b exp=%b", req, cyc, act, exp);
        end
    endtask

    function automatic int span(input logic bcd, input logic [15:0] v);
        int n;
        if (bcd) n = v[15:12]*1000 + v[11:8]*100 + v[7:4]*10 + v[3:0];
        else     n = v;
        if (n == 0) n = bcd ? 10000 : 65536;
        return n;
    endfunction

    function automatic logic exp_out(input logic m, input int n, input int k);
        if (m) return (k != n + 1);
        if (n == 1) return 1'b1;
        if (k >= n && (k % n) == 0) return 1'b0;
        return 1'b1;
    endfunction

    // write at a negedge, then check each cycle k = 0..kmax after the write edge
    task automatic run_case(input string req, input logic m, input logic b,
                            input logic [15:0] v, input int kmax);
        int n;
        n = span(b, v);
        mode_sel = m; bcd_sel = b; load_val = v; load_stb = 1'b1;
        @(posedge clk);
        @(negedge clk);
        load_stb = 1'b0;
        check("R2 null set", null_cnt_o, 1'b1);
        check("R10 out high after write", out_o, 1'b1);
        for (int k = 1; k <= kmax; k++) begin
            @(negedge clk);
            if (k == 1) check("R2 null cleared", null_cnt_o, 1'b0);
            check(req, out_o, exp_out(m, n, k));
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 out reset", out_o, 1'b1);
        check("R1 null reset", null_cnt_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out after reset", out_o, 1'b1);

        // directed corners
        run_case("R3 strobe N=1", 1'b1, 1'b0, 16'd1, 8);
        run_case("R4 strobe no repeat", 1'b1, 1'b0, 16'd5, 30);
        run_case("R5 rate N=2", 1'b0, 1'b0, 16'd2, 12);
        run_case("R6 rate N=1", 1'b0, 1'b0, 16'd1, 20);
        run_case("R8 bcd 0100 rate", 1'b0, 1'b1, 16'h0100, 210);
        run_case("R7 bcd zero strobe", 1'b1, 1'b1, 16'h0000, 10004);
        run_case("R7 bin zero strobe", 1'b1, 1'b0, 16'h0000, 65540);

        // R4 retrigger: new write during a countdown
        mode_sel = 1'b1; bcd_sel = 1'b0; load_val = 16'd10; load_stb = 1'b1;
        @(posedge clk);
        @(negedge clk);
        load_stb = 1'b0;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            check("R4 before retrigger", out_o, 1'b1);
        end
        run_case("R4 retrigger", 1'b1, 1'b0, 16'd6, 20);

        // R9 gate pause in strobe mode: 3 frozen edges delay the pulse
        mode_sel = 1'b1; bcd_sel = 1'b0; load_val = 16'd8; load_stb = 1'b1;
        @(posedge clk);
        @(negedge clk);
        load_stb = 1'b0;
        for (int k = 1; k <= 16; k++) begin
            @(negedge clk);
            check("R9 gate pause", out_o, (k != 12));
            gate = !(k >= 3 && k <= 5);
        end
        gate = 1'b1;

        // constrained random cases
        for (int i = 0; i < 30; i++) begin
            logic m, b;
            logic [15:0] v;
            int n;
            m = 1'($urandom % 2);
            b = 1'($urandom % 2);
            if (b) v = {8'h00, 4'($urandom % 10), 4'($urandom % 10)};
            else   v = 16'($urandom % 60);
            if (span(b, v) < 2 || span(b, v) > 100) v = 16'h0002 + 16'($urandom % 8);
            n = span(b, v);
            if (m) run_case(b ? "R8 rand strobe bcd" : "R3 rand strobe", m, b, v, n + 4);
            else   run_case(b ? "R8 rand rate bcd" : "R5 rand rate", m, b, v, 3 * n + 2);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule